// File: doc/BRIEF.md
# Flash Page Program-Verify Sequencer

This block programs one page of flash memory and checks the result without processor help. A start pulse with a page base address makes it raise the write-enable control and take in the page image on a valid/ready byte stream. It then runs program passes. Each pass writes a page of latch data to the flash, applies a timed program pulse inside a setup window, and reads every byte back in verify mode. From each read-back byte it works out the data for the next attempt.

Bits that should be 0 but still read 1 are programmed again on the next pass. During the early passes, a second reinforcing pulse is applied to bits that have just reached 0. The sequence ends with a done pulse once a whole page verifies, or with a fail pulse once the pass limit is used up. In both cases the write-enable control is dropped for a settling time before the result pulse. Every wait is counted in ticks of a 1 µs strobe.

The stream input follows valid/ready rules. A byte moves on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` is high only during the load phase and never depends on `in_valid`. The source may hold `in_valid` low for any number of cycles, and the sequencer waits for it. All other pins are plain levels or pulses.

Top module: `fpv_seq`

## Requirements
- R1: A start pulse is accepted only while `busy` is low, and `page_base` is captured at that moment. A start pulse that arrives while `busy` is high changes neither the addresses used nor the result.
- R2: After acceptance, `fl_swe` rises. After T_SWE ticks, `in_ready` goes high and the block takes exactly PAGE_BYTES stream bytes, index 0 first. `in_ready` is low at every other time.
- R3: Every write batch is PAGE_BYTES `fl_we` strobes on consecutive cycles, with `fl_pv` low, to addresses base+0 up to base+PAGE_BYTES-1 in rising order.
- R4: After a batch there is a wait of T_PRE ticks. Then `wdt_en` and `fl_psu` rise together. After T_PSU ticks `fl_p` is high for the pulse width, then low for T_HOLD ticks. Then `fl_psu` falls, and after T_HOLD more ticks `wdt_en` falls. `fl_p` is never high without `fl_psu`, and `fl_pv` is never high together with `fl_psu`.
- R5: The pulse width is PW_SHORT ticks while the pass number n (starting at 1) is at most ADD_PASSES, and PW_LONG ticks after that.
- R6: A verify runs as follows. `fl_pv` rises and the block waits T_PVS ticks. Then, for each byte in rising address order, it writes 0xFF (a dummy write with `fl_pv` high), waits T_VRD ticks, and samples `fl_rdata`.
- R7: The next regular batch writes byte i as intended[i] | ~read[i], so a bit is 0 only where it should be 0 and still read 1. The first batch is the page image itself.
- R8: When n ≤ ADD_PASSES, `fl_pv` is cleared and the block waits T_PVE ticks. It then writes a batch whose byte i is intended[i] | read[i], and applies one more pulse of the same width. This happens whether or not the page matched.
- R9: If every byte of a pass matches, `fl_swe` falls and the block waits T_END ticks, then pulses `done`.
- R10: If pass MAX_PASSES still has a mismatch, no further pass starts. `fl_swe` falls, the block waits T_END ticks, then pulses `fail`. Passes that mismatch are followed by a new pass with n+1.
- R11: `done` and `fail` each last one cycle and are never high together. `busy` is high from the cycle after acceptance up to and including that cycle, and low on the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request pulse |
| page_base | input | ADDR_W | Flash address of page byte 0 |
| tick | input | 1 | One-cycle strobe every microsecond |
| in_valid | input | 1 | Page image byte valid |
| in_data | input | 8 | Page image byte |
| in_ready | output | 1 | Sequencer takes a byte this cycle |
| fl_rdata | input | 8 | Flash read data at `fl_addr` |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_swe | output | 1 | Software write-enable control |
| fl_psu | output | 1 | Program setup control |
| fl_p | output | 1 | Program pulse control |
| fl_pv | output | 1 | Program verify control |
| wdt_en | output | 1 | Watchdog enable around the pulse |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Page programmed and verified (pulse) |
| fail | output | 1 | Pass limit reached (pulse) |

## Verification
The hardest situations to reach are a page that takes more than ADD_PASSES passes, so that the pulse widens and the reinforcing batch stops, and a page that never verifies inside MAX_PASSES. Both depend on how slowly the flash cells respond. To reach them, the bench models the flash with a per-byte count of the pulses each byte needs before its pending bits turn to 0. It sets some bytes to need more pulses than ADD_PASSES, and one byte to need more than MAX_PASSES. It also sends a fully erased image, which matches on the first pass but must still get the reinforcing pulse before `done`.

// File: rtl/fpv_pkg.sv
package fpv_pkg;
  typedef enum logic [4:0] {
    S_IDLE, S_SWE, S_LOAD, S_WR, S_WRW, S_PSU, S_PGM, S_POSTP, S_POSTPSU,
    S_PVW, S_VDUM, S_VW, S_VRD, S_PVEND, S_DECIDE, S_FIN, S_REPORT
  } seq_state_e;
endpackage

// File: rtl/fpv_timer.sv
module fpv_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  // expires on the tick that completes `limit` ticks in the current state
  assign expire = tick && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/fpv_bitcalc.sv
module fpv_bitcalc (
  input  logic [7:0] want,
  input  logic [7:0] got,
  output logic [7:0] redo,
  output logic [7:0] reinf
);
  for (genvar b = 0; b < 8; b++) begin : g_bit
    // 0 only where the bit should be 0 but is still 1: program again
    assign redo[b]  = want[b] | ~got[b];
    // 0 only where the bit should be 0 and already is: reinforce
    assign reinf[b] = want[b] | got[b];
  end
endmodule

// File: rtl/fpv_pagebuf.sv
module fpv_pagebuf #(
  parameter int PAGE_BYTES = 128,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             ld_we,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_byte,
  input  logic             vf_we,
  input  logic [IDX_W-1:0] vf_idx,
  input  logic [7:0]       vf_rd,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_reinf,
  output logic [7:0]       wr_byte,
  output logic             vf_bad
);
  logic [7:0] want_q  [PAGE_BYTES];
  logic [7:0] redo_q  [PAGE_BYTES];
  logic [7:0] reinf_q [PAGE_BYTES];
  logic [7:0] redo_n, reinf_n;

  fpv_bitcalc u_calc (
    .want (want_q[vf_idx]),
    .got  (vf_rd),
    .redo (redo_n),
    .reinf(reinf_n)
  );

  assign vf_bad  = (want_q[vf_idx] != vf_rd);
  assign wr_byte = rd_reinf ? reinf_q[rd_idx] : redo_q[rd_idx];

  always_ff @(posedge clk) begin
    if (ld_we) begin
      want_q[ld_idx] <= ld_byte;
      redo_q[ld_idx] <= ld_byte;
    end
    if (vf_we) begin
      redo_q[vf_idx]  <= redo_n;
      reinf_q[vf_idx] <= reinf_n;
    end
  end
endmodule

// File: rtl/fpv_seq.sv
module fpv_seq #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 128,
  parameter int MAX_PASSES = 1000,
  parameter int ADD_PASSES = 6,
  parameter int CNT_W      = 16,
  parameter int T_SWE      = 1,
  parameter int T_PRE      = 5,
  parameter int T_PSU      = 50,
  parameter int T_HOLD     = 5,
  parameter int T_PVS      = 4,
  parameter int T_VRD      = 2,
  parameter int T_PVE      = 2,
  parameter int T_END      = 100,
  parameter int PW_SHORT   = 30,
  parameter int PW_LONG    = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] page_base,
  input  logic              tick,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic [7:0]        fl_rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_swe,
  output logic              fl_psu,
  output logic              fl_p,
  output logic              fl_pv,
  output logic              wdt_en,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  import fpv_pkg::*;

  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int N_W   = $clog2(MAX_PASSES + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PAGE_BYTES - 1);

  seq_state_e        st, st_n;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base;
  logic [N_W-1:0]    n;
  logic              m, reinf_ph, ok;
  logic              expire;
  logic [CNT_W-1:0]  limit;
  logic [7:0]        buf_byte;
  logic              vf_bad;
  logic              early;

  assign early = (n <= N_W'(ADD_PASSES));

  always_comb begin
    case (st)
      S_SWE:     limit = CNT_W'(T_SWE);
      S_WRW:     limit = CNT_W'(T_PRE);
      S_PSU:     limit = CNT_W'(T_PSU);
      S_PGM:     limit = early ? CNT_W'(PW_SHORT) : CNT_W'(PW_LONG);
      S_POSTP,
      S_POSTPSU: limit = CNT_W'(T_HOLD);
      S_PVW:     limit = CNT_W'(T_PVS);
      S_VW:      limit = CNT_W'(T_VRD);
      S_PVEND:   limit = CNT_W'(T_PVE);
      S_FIN:     limit = CNT_W'(T_END);
      default:   limit = CNT_W'(1);
    endcase
  end

  fpv_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(st_n != st), .tick(tick),
    .limit(limit), .expire(expire)
  );

  fpv_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk),
    .ld_we(st == S_LOAD && in_valid), .ld_idx(idx), .ld_byte(in_data),
    .vf_we(st == S_VRD), .vf_idx(idx), .vf_rd(fl_rdata),
    .rd_idx(idx), .rd_reinf(reinf_ph),
    .wr_byte(buf_byte), .vf_bad(vf_bad)
  );

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:    if (start) st_n = S_SWE;
      S_SWE:     if (expire) st_n = S_LOAD;
      S_LOAD:    if (in_valid && idx == LAST) st_n = S_WR;
      S_WR:      if (idx == LAST) st_n = S_WRW;
      S_WRW:     if (expire) st_n = S_PSU;
      S_PSU:     if (expire) st_n = S_PGM;
      S_PGM:     if (expire) st_n = S_POSTP;
      S_POSTP:   if (expire) st_n = S_POSTPSU;
      S_POSTPSU: if (expire) st_n = reinf_ph ? S_DECIDE : S_PVW;
      S_PVW:     if (expire) st_n = S_VDUM;
      S_VDUM:    st_n = S_VW;
      S_VW:      if (expire) st_n = S_VRD;
      S_VRD:     st_n = (idx == LAST) ? S_PVEND : S_VDUM;
      S_PVEND:   if (expire) st_n = early ? S_WR : S_DECIDE;
      S_DECIDE:  st_n = (!m || n == N_W'(MAX_PASSES)) ? S_FIN : S_WR;
      S_FIN:     if (expire) st_n = S_REPORT;
      S_REPORT:  st_n = S_IDLE;
      default:   st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; base <= '0; n <= '0;
      m <= 1'b0; reinf_ph <= 1'b0; ok <= 1'b0;
    end else begin
      st <= st_n;
      case (st)
        S_IDLE: if (start) begin
          base <= page_base; idx <= '0;
        end
        S_LOAD: if (in_valid) begin
          idx <= (idx == LAST) ? '0 : idx + IDX_W'(1);
          if (idx == LAST) begin
            n <= N_W'(1); m <= 1'b0; reinf_ph <= 1'b0;
          end
        end
        S_WR:  idx <= (idx == LAST) ? '0 : idx + IDX_W'(1);
        S_VRD: begin
          m   <= m | vf_bad;
          idx <= (idx == LAST) ? '0 : idx + IDX_W'(1);
        end
        S_PVEND: if (expire && early) reinf_ph <= 1'b1;
        S_DECIDE: begin
          ok <= !m;
          if (m && n != N_W'(MAX_PASSES)) begin
            n <= n + N_W'(1); m <= 1'b0; reinf_ph <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign in_ready = (st == S_LOAD);
  assign fl_addr  = base + ADDR_W'(idx);
  assign fl_we    = (st == S_WR) || (st == S_VDUM);
  assign fl_wdata = (st == S_VDUM) ? 8'hFF : buf_byte;
  assign fl_swe   = !(st == S_IDLE || st == S_FIN || st == S_REPORT);
  assign fl_psu   = (st == S_PSU) || (st == S_PGM) || (st == S_POSTP);
  assign fl_p     = (st == S_PGM);
  assign wdt_en   = fl_psu || (st == S_POSTPSU);
  assign fl_pv    = (st == S_PVW) || (st == S_VDUM) || (st == S_VW) || (st == S_VRD);
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_REPORT) && ok;
  assign fail     = (st == S_REPORT) && !ok;
endmodule

// File: rtl/fpv_chk.sv
module fpv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       in_ready,
  input logic       fl_we,
  input logic [7:0] fl_wdata,
  input logic       fl_swe,
  input logic       fl_psu,
  input logic       fl_p,
  input logic       fl_pv,
  input logic       wdt_en,
  input logic       busy,
  input logic       done,
  input logic       fail
);
  p_busy_needs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  p_ready_in_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && fl_swe && !fl_pv && !fl_psu));
  p_write_outside_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> (!fl_psu && fl_swe));
  p_pulse_in_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_p |-> (fl_psu && wdt_en));
  p_verify_excl_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_pv |-> !fl_psu);
  p_dummy_ff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fl_pv) |-> (fl_wdata == 8'hFF));
  p_swe_off_at_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> (!fl_swe && $past(!fl_swe)));
  p_result_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  p_result_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |=> (!done && !fail && !busy));
  p_result_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> busy);
endmodule

bind fpv_seq fpv_chk u_chk (.*);

// File: tb/sim_fpv_seq.sv
`timescale 1ns/1ps
module sim_fpv_seq;
  localparam int PAGE = 8;
  localparam int MAXP = 10;
  localparam int ADDP = 6;
  localparam int PWS  = 10;
  localparam int PWL  = 20;
  localparam int TEND = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] page_base = '0;
  logic tick = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic [7:0] fl_rdata;
  logic [15:0] fl_addr;
  logic [7:0] fl_wdata;
  logic fl_we, fl_swe, fl_psu, fl_p, fl_pv, wdt_en, busy, done, fail;

  always #2.5 clk = ~clk;

  fpv_seq #(.ADDR_W(16), .PAGE_BYTES(PAGE), .MAX_PASSES(MAXP), .ADD_PASSES(ADDP),
            .T_END(TEND), .PW_SHORT(PWS), .PW_LONG(PWL)) u0 (.*);

  int nchk = 0, nfail = 0;
  // bench flash model
  logic [7:0] mem [PAGE];
  logic [7:0] latch [PAGE];
  int pcnt [PAGE];
  int need [PAGE];
  logic [7:0] img [PAGE];
  logic [15:0] cur_base;
  // reference tracking
  bit kind_reinf;
  int wcnt, vcnt, iter, phigh, swe_low, results;
  bit p_last, pv_last, mbusy;

  assign fl_rdata = mem[int'(fl_addr - cur_base) & (PAGE-1)];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the behavioural reference
  always @(negedge clk) if (rst_n) begin
    chk(busy == mbusy, "R11", "busy", busy, mbusy);
    if (fl_we && !fl_pv) begin
      logic [7:0] e;
      if (wcnt == 0 && !kind_reinf) iter++;
      e = kind_reinf ? (img[wcnt] | mem[wcnt]) : (img[wcnt] | ~mem[wcnt]);
      chk(fl_addr == cur_base + 16'(wcnt), "R3", "write address", fl_addr, cur_base + 16'(wcnt));
      chk(fl_wdata == e, kind_reinf ? "R8" : "R7", "batch byte", fl_wdata, e);
      latch[wcnt] = fl_wdata;
      wcnt++;
      if (wcnt == PAGE) begin wcnt = 0; kind_reinf = 1'b0; end
    end
    if (fl_we && fl_pv) begin
      chk(fl_wdata == 8'hFF, "R6", "dummy data", fl_wdata, 8'hFF);
      chk(fl_addr == cur_base + 16'(vcnt), "R6", "verify address", fl_addr, cur_base + 16'(vcnt));
      vcnt = (vcnt + 1) % PAGE;
    end
    if (fl_p && !p_last) begin
      for (int i = 0; i < PAGE; i++)
        if (((~latch[i]) & mem[i]) != 8'h00) begin
          pcnt[i]++;
          if (pcnt[i] >= need[i]) mem[i] = mem[i] & latch[i];
        end
    end
    if (fl_p) phigh++;
    else if (phigh > 0) begin
      chk(phigh == ((iter <= ADDP) ? PWS : PWL), "R5", "pulse width", phigh, (iter <= ADDP) ? PWS : PWL);
      phigh = 0;
    end
    if (!fl_pv && pv_last && iter <= ADDP) kind_reinf = 1'b1;
    if (!fl_swe) swe_low++; else swe_low = 0;
    if (done || fail) results++;
    p_last = fl_p; pv_last = fl_pv;
    if (done || fail) mbusy = 1'b0;
    else if (start && !mbusy) mbusy = 1'b1;
  end

  task automatic run_case(input logic [15:0] base, input bit poke);
    int maxneed = 1, exp_iter, cyc = 0, r0;
    bit exp_fail;
    for (int i = 0; i < PAGE; i++) begin
      mem[i] = 8'hFF; latch[i] = 8'hFF; pcnt[i] = 0;
      if (img[i] != 8'hFF && need[i] > maxneed) maxneed = need[i];
    end
    exp_fail = (maxneed > MAXP);
    exp_iter = exp_fail ? MAXP : maxneed;
    cur_base = base; kind_reinf = 1'b0; wcnt = 0; vcnt = 0; iter = 0; phigh = 0;
    r0 = results;
    @(posedge clk); #1; start = 1'b1; page_base = base;
    @(posedge clk); #1; start = 1'b0; page_base = 16'hDEAD;
    for (int i = 0; i < PAGE; i++) begin
      bit rdy;
      if (i % 2 == 1) begin in_valid = 1'b0; @(posedge clk); #1; end
      in_valid = 1'b1; in_data = img[i];
      do begin rdy = in_ready; @(posedge clk); #1; end while (!rdy);
    end
    in_valid = 1'b0;
    if (poke) begin
      repeat (40) @(posedge clk); #1; start = 1'b1; page_base = 16'h0100;
      @(posedge clk); #1; start = 1'b0;
    end
    while (results == r0 && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (done || fail) begin
        chk(fail == exp_fail, exp_fail ? "R10" : "R9", "fail flag", fail, exp_fail);
        chk(done == !exp_fail, exp_fail ? "R10" : "R9", "done flag", done, !exp_fail);
        chk(iter == exp_iter, "R10", "pass count", iter, exp_iter);
        chk(swe_low >= TEND, "R9", "swe low cycles", swe_low, TEND);
        if (!exp_fail)
          for (int i = 0; i < PAGE; i++)
            chk(mem[i] == img[i], "R9", "cell content", mem[i], img[i]);
      end
    end
    chk(results == r0 + 1, "R11", "one result (watchdog)", results - r0, 1);
    @(negedge clk);
    chk(!done && !fail && !busy, "R11", "result is one cycle", {done, fail, busy}, 0);
  endtask

  initial begin
    mbusy = 1'b0; results = 0; swe_low = 0; p_last = 0; pv_last = 0;
    for (int i = 0; i < PAGE; i++) begin mem[i] = 8'hFF; latch[i] = 8'hFF; end
    repeat (3) @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk({busy, fl_swe, fl_psu, fl_p, fl_pv, fl_we, in_ready, done, fail} == 0,
        "R11", "reset outputs", {busy, fl_swe, fl_psu, fl_p, fl_pv, fl_we, in_ready, done, fail}, 0);
    // R9: modest page, up to 4 pulses, short widths only
    for (int i = 0; i < PAGE; i++) begin img[i] = 8'(8'h5A ^ (i * 8'h13)); need[i] = (i % 4) + 1; end
    run_case(16'h0400, 1'b0);
    // R5/R8/R1: slow bytes push past the early passes; start poked mid-run is ignored
    for (int i = 0; i < PAGE; i++) begin img[i] = 8'(8'h0F << (i % 5)); need[i] = (i == 3) ? 8 : (i % 3) + 1; end
    run_case(16'h2000, 1'b1);
    // R10: one byte never programs within the pass limit
    for (int i = 0; i < PAGE; i++) begin img[i] = 8'h00; need[i] = (i == 5) ? 12 : 2; end
    run_case(16'h3F00, 1'b0);
    // R8/R9: erased image matches at once but still gets the reinforcing pulse
    for (int i = 0; i < PAGE; i++) begin img[i] = 8'hFF; need[i] = 1; end
    run_case(16'h0010, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule